// File: doc/BRIEF.md
# Calibrated One-Second Tick Generator

This block turns a 32.768 kHz oscillator, delivered as a one-cycle enable in the system clock domain, into the timebase of a real-time clock. It produces three outputs. The first is a one-cycle tick once per second for the calendar logic. The second is a trimmed 1 Hz square wave. The third is an untrimmed 512 Hz square wave. A level output chooses between a static level and one of the two test waves.

Frequency trim does not change every second. The block keeps a window of whole seconds, and only the last second of each window is made longer or shorter by a whole number of oscillator cycles. When the clock is slowed, the window is the long one (960 s by default) and that second gains `CAL_STEP`×magnitude cycles. When it is sped up, the window is half as long and that second loses the same number of cycles. Each step therefore speeds the clock about twice as much as it slows it.

A second enable from a free-running reference clock watches the oscillator. When several oscillator periods in a row pass with no edge, a sticky failure flag is raised. A stop input freezes every divider until it is released.

Top module: `rtc_tick_gen`

## Requirements
- R1: With trim magnitude 0, `sec_tick` is high for exactly one system cycle after every 2^DIV_BITS counted oscillator enables.
- R2: With `cal_sign`=0, seconds are counted in windows of SLOW_WIN, starting at reset. The last second of each window lasts 2^DIV_BITS + CAL_STEP×`cal_mag` enables, and every other second is nominal.
- R3: With `cal_sign`=1, the window is FAST_WIN seconds long. Its last second lasts 2^DIV_BITS − CAL_STEP×`cal_mag` enables.
- R4: `wave_1hz` is high while fewer than 2^(DIV_BITS−1) enables have been counted since the last tick, and low for the rest of the second, including any stretched part. It therefore carries the trim.
- R5: `wave_512hz` is bit FAST_HALF_LOG of a count of all enables taken since reset, and the trim setting never affects it.
- R6: `irq_out` equals `out_level` when `test_en`=0. When `test_en`=1, it equals `wave_1hz` if `test_slow`=1 and `wave_512hz` if `test_slow`=0.
- R7: While `stop`=1, enables are not counted: no tick is issued, both waves hold, and the second resumes where it stopped.
- R8: `osc_fail` is 1 out of reset and drops to 0 one cycle after a `fail_clr` pulse.
- R9: `osc_fail` sets once MISS_LIMIT consecutive windows of REF_WIN reference enables pass with no oscillator enable. Fewer missed windows leave it clear.
- R10: Once set, `osc_fail` stays set until `fail_clr`. If a detection and a clear happen in the same cycle, the detection wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, first power-up |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| ref_en | input | 1 | One-cycle pulse per reference clock period |
| stop | input | 1 | Freezes all dividers |
| cal_sign | input | 1 | 0 slows the clock, 1 speeds it |
| cal_mag | input | 5 | Trim magnitude, 0 to 31 |
| out_level | input | 1 | Static level for irq_out |
| test_en | input | 1 | Selects a test wave on irq_out |
| test_slow | input | 1 | Test wave choice: 1 gives the 1 Hz wave, 0 gives the 512 Hz wave |
| fail_clr | input | 1 | Write pulse that clears osc_fail |
| sec_tick | output | 1 | One-cycle tick per second |
| wave_1hz | output | 1 | Trimmed 1 Hz square wave |
| wave_512hz | output | 1 | Untrimmed 512 Hz square wave |
| irq_out | output | 1 | Selected output level |
| osc_fail | output | 1 | Sticky oscillator failure flag |

## Verification
The tick is measured in oscillator enables per second across several trim patterns: zero trim, a mid magnitude slowing, the same magnitude speeding, and full scale in both directions. These patterns show whether the right second in the window is adjusted, whether the window length follows the sign, and whether the step size scales correctly. A pause taken in the middle of a second shows whether stop freezes the count or restarts it. Oscillator gaps just below and well above the miss limit show whether the failure detector counts whole missed windows. Both waves and the output mux are compared with a model on every cycle while the settings change.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

  typedef enum logic [1:0] {
    PIN_LEVEL = 2'd0,
    PIN_FAST  = 2'd1,
    PIN_SLOW  = 2'd2
  } pin_src_e;

  function automatic pin_src_e pin_source(input logic test_en, input logic test_slow);
    if (!test_en)      return PIN_LEVEL;
    else if (test_slow) return PIN_SLOW;
    else               return PIN_FAST;
  endfunction

endpackage

// File: rtl/rtc_trim_window.sv
module rtc_trim_window #(
  parameter int SLOW_WIN = 960,
  parameter int FAST_WIN = 480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_done,
  input  logic cal_sign,
  output logic adj_now
);
  localparam int WMAX = (SLOW_WIN > FAST_WIN) ? SLOW_WIN : FAST_WIN;
  localparam int WW   = (WMAX > 2) ? $clog2(WMAX) : 1;

  logic [WW-1:0] win_q;
  logic [WW-1:0] last_idx;

  // the window length follows the sign of the trim
  assign last_idx = cal_sign ? WW'(FAST_WIN - 1) : WW'(SLOW_WIN - 1);
  assign adj_now  = (win_q >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        win_q <= '0;
    else if (sec_done) win_q <= adj_now ? '0 : win_q + 1'b1;
  end
endmodule

// File: rtl/rtc_second_div.sv
module rtc_second_div #(
  parameter int DIV_BITS = 15,
  parameter int CAL_STEP = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       stop,
  input  logic       cal_sign,
  input  logic [4:0] cal_mag,
  input  logic       adj_now,
  output logic       sec_done,
  output logic       sec_tick,
  output logic       wave_1hz
);
  localparam int CW = DIV_BITS + 1;
  localparam logic [CW-1:0] NOM  = CW'(2 ** DIV_BITS);
  localparam logic [CW-1:0] HALF = CW'(2 ** (DIV_BITS - 1));
  localparam logic [CW-1:0] STEP = CW'(CAL_STEP);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] delta;
  logic [CW-1:0] len;
  logic          step;

  assign delta = STEP * CW'(cal_mag);

  always_comb begin
    len = NOM;
    if (adj_now) len = cal_sign ? (NOM - delta) : (NOM + delta);
  end

  assign step     = osc_en & ~stop;
  // ">=" keeps the second short if the trim is lowered mid-second
  assign sec_done = step & (cnt_q >= (len - 1'b1));
  assign wave_1hz = (cnt_q < HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= sec_done;
      if (sec_done)  cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_fast_wave.sv
module rtc_fast_wave #(
  parameter int FAST_HALF_LOG = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic stop,
  output logic wave_fast
);
  logic [FAST_HALF_LOG:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (osc_en && !stop) cnt_q <= cnt_q + 1'b1;
  end

  assign wave_fast = cnt_q[FAST_HALF_LOG];
endmodule

// File: rtl/rtc_osc_monitor.sv
module rtc_osc_monitor #(
  parameter int REF_WIN    = 4,
  parameter int MISS_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic ref_en,
  input  logic fail_clr,
  output logic osc_fail
);
  localparam int RW = (REF_WIN > 2) ? $clog2(REF_WIN) : 1;
  localparam int MW = $clog2(MISS_LIMIT + 1);

  logic [RW-1:0] ref_q;
  logic [MW-1:0] miss_q;
  logic          win_end;
  logic          fail_hit;

  assign win_end  = ~osc_en & ref_en & (ref_q == RW'(REF_WIN - 1));
  assign fail_hit = win_end & (miss_q >= MW'(MISS_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      miss_q <= '0;
    end else if (osc_en) begin
      ref_q  <= '0;
      miss_q <= '0;
    end else if (ref_en) begin
      if (win_end) begin
        ref_q <= '0;
        if (miss_q != MW'(MISS_LIMIT)) miss_q <= miss_q + 1'b1;
      end else begin
        ref_q <= ref_q + 1'b1;
      end
    end
  end

  // set at power-up; a detection outranks a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        osc_fail <= 1'b1;
    else if (fail_hit) osc_fail <= 1'b1;
    else if (fail_clr) osc_fail <= 1'b0;
  end
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
  import rtc_tick_pkg::*;
#(
  parameter int DIV_BITS      = 15,
  parameter int FAST_HALF_LOG = 5,
  parameter int CAL_STEP      = 64,
  parameter int SLOW_WIN      = 960,
  parameter int FAST_WIN      = 480,
  parameter int REF_WIN       = 4,
  parameter int MISS_LIMIT    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       ref_en,
  input  logic       stop,
  input  logic       cal_sign,
  input  logic [4:0] cal_mag,
  input  logic       out_level,
  input  logic       test_en,
  input  logic       test_slow,
  input  logic       fail_clr,
  output logic       sec_tick,
  output logic       wave_1hz,
  output logic       wave_512hz,
  output logic       irq_out,
  output logic       osc_fail
);
  logic     sec_done;
  logic     adj_now;
  pin_src_e src;

  rtc_trim_window #(.SLOW_WIN(SLOW_WIN), .FAST_WIN(FAST_WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .sec_done(sec_done), .cal_sign(cal_sign), .adj_now(adj_now)
  );

  rtc_second_div #(.DIV_BITS(DIV_BITS), .CAL_STEP(CAL_STEP)) u_div (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop), .cal_sign(cal_sign),
    .cal_mag(cal_mag), .adj_now(adj_now), .sec_done(sec_done), .sec_tick(sec_tick),
    .wave_1hz(wave_1hz)
  );

  rtc_fast_wave #(.FAST_HALF_LOG(FAST_HALF_LOG)) u_fast (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop), .wave_fast(wave_512hz)
  );

  rtc_osc_monitor #(.REF_WIN(REF_WIN), .MISS_LIMIT(MISS_LIMIT)) u_mon (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .ref_en(ref_en), .fail_clr(fail_clr),
    .osc_fail(osc_fail)
  );

  assign src = pin_source(test_en, test_slow);

  always_comb begin
    unique case (src)
      PIN_SLOW: irq_out = wave_1hz;
      PIN_FAST: irq_out = wave_512hz;
      default:  irq_out = out_level;
    endcase
  end
endmodule

// File: rtl/rtc_tick_gen_chk.sv
module rtc_tick_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic stop,
  input logic test_en,
  input logic out_level,
  input logic fail_clr,
  input logic sec_tick,
  input logic wave_1hz,
  input logic wave_512hz,
  input logic irq_out,
  input logic osc_fail
);
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick); // R1

  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop) |-> !sec_tick); // R7

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> ($stable(wave_512hz) && $stable(wave_1hz))); // R7

  AST_LEVEL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> (irq_out == out_level)); // R6

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_fail && !fail_clr) |=> osc_fail); // R10
endmodule

bind rtc_tick_gen rtc_tick_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .test_en(test_en), .out_level(out_level),
  .fail_clr(fail_clr), .sec_tick(sec_tick), .wave_1hz(wave_1hz), .wave_512hz(wave_512hz),
  .irq_out(irq_out), .osc_fail(osc_fail)
);

// File: tb/rtc_tick_gen_test.sv
module rtc_tick_gen_test;
  localparam int DB = 8, FH = 2, STP = 2, SW = 4, FW = 2;
  localparam int NOMS = 2 ** DB;
  localparam int HALFS = NOMS / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_en = 1'b0, ref_en = 1'b1, stop = 1'b0, cal_sign = 1'b0;
  logic [4:0] cal_mag = 5'd0;
  logic out_level = 1'b0, test_en = 1'b0, test_slow = 1'b0, fail_clr = 1'b0;
  logic sec_tick, wave_1hz, wave_512hz, irq_out, osc_fail;

  int checks = 0, errors = 0;
  int total = 0, last_tick = 0, stop_ticks = 0;
  bit osc_run = 1'b1, done = 1'b0;
  int exp_len[$];
  string exp_req[$];

  always #2.5 clk = ~clk;

  rtc_tick_gen #(.DIV_BITS(DB), .FAST_HALF_LOG(FH), .CAL_STEP(STP), .SLOW_WIN(SW),
                 .FAST_WIN(FW), .REF_WIN(4), .MISS_LIMIT(4)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .ref_en(ref_en), .stop(stop),
    .cal_sign(cal_sign), .cal_mag(cal_mag), .out_level(out_level), .test_en(test_en),
    .test_slow(test_slow), .fail_clr(fail_clr), .sec_tick(sec_tick), .wave_1hz(wave_1hz),
    .wave_512hz(wave_512hz), .irq_out(irq_out), .osc_fail(osc_fail));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // oscillator source: one enable every other cycle while running
  always @(negedge clk) osc_en <= osc_run && !osc_en;

  // count enables the design should take
  always @(posedge clk) if (rst_n && osc_en && !stop) total++;

  // monitor: pops expected second lengths and models the waves
  always @(negedge clk) begin
    if (rst_n) begin
      bit e1, e512, ep;
      if (sec_tick) begin
        if (stop) stop_ticks++;
        if (exp_len.size() > 0) begin
          int want; string r;
          want = exp_len.pop_front(); r = exp_req.pop_front();
          check(total - last_tick == want, r, total - last_tick, want);
        end
        last_tick = total;
      end
      e1 = (total - last_tick) < HALFS;
      e512 = ((total >> FH) & 1) != 0;
      check(wave_1hz == e1, "R4", int'(wave_1hz), int'(e1));
      check(wave_512hz == e512, "R5", int'(wave_512hz), int'(e512));
      ep = test_en ? (test_slow ? e1 : e512) : out_level;
      check(irq_out == ep, "R6", int'(irq_out), int'(ep));
    end
  end

  task automatic push(input int len, input string r);
    exp_len.push_back(len); exp_req.push_back(r);
  endtask

  task automatic drain();
    wait (exp_len.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(osc_fail == 1'b1, "R8", int'(osc_fail), 1);
    check(sec_tick == 1'b0, "R1", int'(sec_tick), 0);
    fail_clr = 1'b1; @(negedge clk); fail_clr = 1'b0;
    check(osc_fail == 1'b0, "R8", int'(osc_fail), 0);

    // zero trim, slow wave on the pin
    test_en = 1'b1; test_slow = 1'b1;
    repeat (4) push(NOMS, "R1");
    drain();
    // slowing, mid magnitude: window of 4, last one stretched
    cal_mag = 5'd5; test_slow = 1'b0;
    repeat (2) begin
      repeat (3) push(NOMS, "R2");
      push(NOMS + STP * 5, "R2");
    end
    drain();
    // speeding, same magnitude: window of 2
    cal_sign = 1'b1; test_en = 1'b0; out_level = 1'b1;
    repeat (2) begin push(NOMS, "R3"); push(NOMS - STP * 5, "R3"); end
    drain();
    cal_mag = 5'd31; out_level = 1'b0;
    push(NOMS, "R3"); push(NOMS - STP * 31, "R3");
    drain();
    cal_sign = 1'b0; test_en = 1'b1; test_slow = 1'b1;
    repeat (3) push(NOMS, "R2");
    push(NOMS + STP * 31, "R2");
    drain();

    // pause mid-second: the length in counted enables is unchanged
    cal_mag = 5'd0;
    push(NOMS, "R7");
    repeat (100) @(negedge clk);
    stop = 1'b1;
    repeat (300) @(negedge clk);
    stop = 1'b0;
    check(stop_ticks == 0, "R7", stop_ticks, 0);
    drain();

    // short oscillator gap: fewer than four missed windows
    osc_run = 1'b0; repeat (8) @(negedge clk); osc_run = 1'b1;
    repeat (10) @(negedge clk);
    check(osc_fail == 1'b0, "R9", int'(osc_fail), 0);
    // long gap: flag sets and holds after the oscillator returns
    osc_run = 1'b0; repeat (40) @(negedge clk);
    check(osc_fail == 1'b1, "R9", int'(osc_fail), 1);
    osc_run = 1'b1; repeat (20) @(negedge clk);
    check(osc_fail == 1'b1, "R10", int'(osc_fail), 1);
    fail_clr = 1'b1; @(negedge clk); fail_clr = 1'b0;
    check(osc_fail == 1'b0, "R10", int'(osc_fail), 0);
    // clear during a gap: the next detection wins over the pending clear
    osc_run = 1'b0; fail_clr = 1'b1; repeat (40) @(negedge clk);
    check(osc_fail == 1'b1, "R10", int'(osc_fail), 1);
    fail_clr = 1'b0; osc_run = 1'b1;
    repeat (10) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 150000) begin @(posedge clk); n++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", n, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule